// File: doc/BRIEF.md
# Dual-Mode Serial Register Port

This block is the slave end of a serial link that lets an external host read and write a small bank of clock registers and a user RAM. The static input `spi_mode` selects the wire protocol. When it is high, the block uses four-wire SPI: bits are moved most significant first, data arrives on `sdi` and leaves on `sdo`, and either idle level of the serial clock is accepted. When it is low, the block uses a three-wire mode: the host and the block share one data line, and every byte is moved least significant first. `sdo_oe` tells the board when the block drives that shared line.

A frame opens when chip enable rises. The first byte is a header: bit 7 gives the direction and bits 6:0 give the starting location. Data bytes follow for as long as chip enable stays high, and the location pointer advances by one after each byte. A read frame first freezes a copy of the time registers, so a burst always returns a consistent set of values while the live counter keeps moving. All serial inputs are resynchronised to the system clock `clk`. The live seconds counter advances by one on each `tick` pulse.

Top module: `dual_serial_regport`

## Requirements
- R1: With `spi_mode`=1, header and data bytes are shifted MSB first, in on `sdi` and out on `sdo`. With `spi_mode`=0, every byte is shifted LSB first on a single shared line.
- R2: Header bit 7 = 1 marks a write and 0 marks a read. Bits 6:0 give the first location. The bytes that follow are data.
- R3: While chip enable stays high, each further data byte accesses the next location.
- R4: In the clock window (locations 0x00–0x1F), a burst wraps from 0x1F back to 0x00. For writes these are headers 0x80–0x9F.
- R5: In the RAM window (locations 0x20–0x7F), a burst wraps from 0x7F back to 0x20.
- R6: Locations 0x00–0x06 read from a copy taken when a read header completes, and the copy does not change for the rest of that frame. Each `tick` pulse adds 1 to the live location 0x00, and later read frames see the new value.
- R7: The level of the serial clock at the rise of chip enable is taken as its idle level. Input bits are captured on edges that leave the idle level, and output bits are launched on edges that return to it.
- R8: `sdo_oe` is 0 while chip enable is low and throughout the header byte. In three-wire mode it also stays 0 throughout write data.
- R9: Locations 0x10–0x1F are read-only. They read as 0x00, and writes to them are ignored.
- R10: If chip enable falls before the eighth bit of a data byte, that byte is dropped and no location changes.
- R11: If a write to location 0x00 commits in the same `clk` cycle as a `tick`, the written value is stored. A `tick` one cycle later adds 1 to that value.
- R12: After reset, `sdo_oe` is 0 and locations 0x00–0x1F read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_mode | input | 1 | Static protocol select: 1 = SPI, 0 = three-wire |
| ce | input | 1 | Active-high frame enable from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in; in three-wire mode, the shared line |
| tick | input | 1 | One-cycle pulse that advances the live seconds location |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | High while the block drives the data line |

## Verification
The tightest interaction is between a host write to the seconds location and a `tick` landing in the same system-clock cycle. The bench counts the synchroniser and strobe registers from the eighth capture edge to the commit cycle, and places a single `tick` either exactly on the commit cycle or one cycle after it. It then reads the location back and expects the written value in the first case and the written value plus one in the second. A second interaction is checked by pulsing `tick` in the middle of a read burst: the wrapped re-read of location 0x00 must return the value frozen when the header completed, and a fresh frame must return the advanced value.

// File: rtl/dsrp_pkg.sv
package dsrp_pkg;

  typedef enum logic {
    PH_HEADER,
    PH_PAYLOAD
  } frame_phase_e;

  typedef struct packed {
    logic       wr;
    logic [6:0] loc;
  } header_t;

endpackage

// File: rtl/dsrp_sync.sv
module dsrp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic ce,
  input  logic sdi,
  output logic sclk_s,
  output logic ce_s,
  output logic sdi_s
);

  logic [2:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= {sclk, ce, sdi};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign {sclk_s, ce_s, sdi_s} = pipe[STAGES-1];

endmodule

// File: rtl/dsrp_shifter.sv
module dsrp_shifter (
  input  logic       clk,
  input  logic       rst,
  input  logic       spi_mode,
  input  logic       sclk_s,
  input  logic       ce_s,
  input  logic       sdi_s,
  input  logic [7:0] tx_data,
  output logic [7:0] byte_q,
  output logic       byte_stb,
  output logic       sdo
);

  logic       idle_lvl;
  logic       sclk_d;
  logic       ce_d;
  logic [2:0] bit_cnt;
  logic [7:0] rx_sh;
  logic [7:0] tx_byte;
  logic       edge_seen;
  logic       cap_edge;
  logic       launch_edge;
  logic [7:0] rx_next;

  function automatic logic pick_bit(input logic [7:0] b, input logic [2:0] n,
                                    input logic msb_first);
    return msb_first ? b[3'd7 - n] : b[n];
  endfunction

  assign edge_seen   = sclk_s ^ sclk_d;
  assign cap_edge    = ce_s && ce_d && edge_seen && (sclk_s != idle_lvl);
  assign launch_edge = ce_s && ce_d && edge_seen && (sclk_s == idle_lvl);
  assign rx_next     = spi_mode ? {rx_sh[6:0], sdi_s} : {sdi_s, rx_sh[7:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_lvl <= 1'b0;
      sclk_d   <= 1'b0;
      ce_d     <= 1'b0;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_byte  <= '0;
      byte_q   <= '0;
      byte_stb <= 1'b0;
      sdo      <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      ce_d     <= ce_s;
      byte_stb <= 1'b0;
      if (ce_s && !ce_d) idle_lvl <= sclk_s;
      if (!ce_s) begin
        bit_cnt <= '0;
      end else if (cap_edge) begin
        rx_sh   <= rx_next;
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_q   <= rx_next;
          byte_stb <= 1'b1;
        end
      end
      if (launch_edge) begin
        if (bit_cnt == 3'd0) begin
          tx_byte <= tx_data;
          sdo     <= pick_bit(tx_data, bit_cnt, spi_mode);
        end else begin
          sdo     <= pick_bit(tx_byte, bit_cnt, spi_mode);
        end
      end
    end
  end

  // R7: a whole byte needs eight distinct capture edges, so strobes never abut
  byte_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    byte_stb |=> !byte_stb);

  // R10: with the frame closed no byte can complete
  abort_no_byte_chk: assert property (@(posedge clk) disable iff (rst)
    !ce_s |=> !byte_stb);

endmodule

// File: rtl/dsrp_regfile.sv
module dsrp_regfile #(
  parameter int LOC_W     = 7,
  parameter int CLK_REGS  = 32,
  parameter int RW_REGS   = 16,
  parameter int TIME_REGS = 7,
  parameter int RAM_WORDS = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             snap_req,
  input  logic             we,
  input  logic [LOC_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [LOC_W-1:0] raddr,
  output logic [7:0]       rd_data
);

  localparam int               LIVE_AW  = $clog2(RW_REGS);
  localparam int               SNAP_AW  = $clog2(TIME_REGS);
  localparam int               RAM_AW   = $clog2(RAM_WORDS);
  localparam logic [LOC_W-1:0] CLK_LIM  = LOC_W'(CLK_REGS);
  localparam logic [LOC_W-1:0] RW_LIM   = LOC_W'(RW_REGS);
  localparam logic [LOC_W-1:0] TIME_LIM = LOC_W'(TIME_REGS);
  localparam logic [LOC_W:0]   RAM_SPAN = (LOC_W+1)'(RAM_WORDS);

  logic [7:0]       live [RW_REGS];
  logic [7:0]       snap [TIME_REGS];
  logic [7:0]       ram  [RAM_WORDS];
  logic [7:0]       ram_q;
  logic [7:0]       clk_q;
  logic             sel_ram;
  logic [LOC_W-1:0] woff;
  logic [LOC_W-1:0] roff;
  logic             whit;
  logic             rhit;

  assign woff = waddr - CLK_LIM;
  assign roff = raddr - CLK_LIM;
  assign whit = (waddr >= CLK_LIM) && ({1'b0, woff} < RAM_SPAN);
  assign rhit = (raddr >= CLK_LIM) && ({1'b0, roff} < RAM_SPAN);

  // live counters: the tick bumps location zero, a host write overrides it
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < RW_REGS; i++) live[i] <= '0;
    end else begin
      if (tick) live[0] <= live[0] + 8'd1;
      for (int i = 0; i < RW_REGS; i++)
        if (we && waddr == LOC_W'(i)) live[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TIME_REGS; i++) snap[i] <= '0;
    end else if (snap_req) begin
      for (int i = 0; i < TIME_REGS; i++) snap[i] <= live[i];
    end
  end

  // block-RAM style: synchronous write, registered read, no reset
  always_ff @(posedge clk) begin
    if (we && whit) ram[woff[RAM_AW-1:0]] <= wdata;
    ram_q <= ram[rhit ? roff[RAM_AW-1:0] : '0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q   <= '0;
      sel_ram <= 1'b0;
    end else begin
      sel_ram <= rhit;
      if (raddr < TIME_LIM)    clk_q <= snap[raddr[SNAP_AW-1:0]];
      else if (raddr < RW_LIM) clk_q <= live[raddr[LIVE_AW-1:0]];
      else                     clk_q <= '0;
    end
  end

  assign rd_data = sel_ram ? ram_q : clk_q;

  // R11
  write_beats_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (we && waddr == '0) |=> live[0] == $past(wdata));

  // R6
  snap_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !snap_req) |=> snap[0] == $past(snap[0]));

endmodule

// File: rtl/dual_serial_regport.sv
module dual_serial_regport #(
  parameter int SYNC_STAGES = 2,
  parameter int CLK_REGS    = 32,
  parameter int RW_REGS     = 16,
  parameter int TIME_REGS   = 7,
  parameter int RAM_WORDS   = 96
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_mode,
  input  logic ce,
  input  logic sclk,
  input  logic sdi,
  input  logic tick,
  output logic sdo,
  output logic sdo_oe
);

  import dsrp_pkg::*;

  localparam int               LOC_W    = 7;
  localparam logic [LOC_W-1:0] CLK_LIM  = LOC_W'(CLK_REGS);
  localparam logic [LOC_W-1:0] CLK_LAST = LOC_W'(CLK_REGS - 1);
  localparam logic [LOC_W-1:0] RAM_LAST = LOC_W'(CLK_REGS + RAM_WORDS - 1);

  logic             sclk_s, ce_s, sdi_s;
  logic [7:0]       byte_q;
  logic             byte_stb;
  logic [7:0]       rd_data;
  frame_phase_e     phase;
  logic             dir_wr;
  logic [LOC_W-1:0] ptr;
  logic [LOC_W-1:0] ptr_next;
  header_t          hdr;
  logic             snap_req;
  logic             we;
  logic             stepping;

  dsrp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk(sclk), .ce(ce), .sdi(sdi),
    .sclk_s(sclk_s), .ce_s(ce_s), .sdi_s(sdi_s)
  );

  dsrp_shifter u_shift (
    .clk(clk), .rst(rst), .spi_mode(spi_mode),
    .sclk_s(sclk_s), .ce_s(ce_s), .sdi_s(sdi_s),
    .tx_data(rd_data), .byte_q(byte_q), .byte_stb(byte_stb), .sdo(sdo)
  );

  dsrp_regfile #(
    .LOC_W(LOC_W), .CLK_REGS(CLK_REGS), .RW_REGS(RW_REGS),
    .TIME_REGS(TIME_REGS), .RAM_WORDS(RAM_WORDS)
  ) u_regs (
    .clk(clk), .rst(rst), .tick(tick), .snap_req(snap_req),
    .we(we), .waddr(ptr), .wdata(byte_q), .raddr(ptr), .rd_data(rd_data)
  );

  assign hdr      = header_t'(byte_q);
  assign snap_req = byte_stb && (phase == PH_HEADER) && !hdr.wr;
  assign stepping = byte_stb && (phase == PH_PAYLOAD);
  assign we       = stepping && dir_wr;

  // each window wraps onto its own first location
  always_comb begin
    if (ptr < CLK_LIM) ptr_next = (ptr == CLK_LAST) ? '0 : ptr + 1'b1;
    else               ptr_next = (ptr == RAM_LAST) ? CLK_LIM : ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_HEADER;
      dir_wr <= 1'b0;
      ptr    <= '0;
    end else if (!ce_s) begin
      phase  <= PH_HEADER;
      dir_wr <= 1'b0;
    end else if (byte_stb) begin
      if (phase == PH_HEADER) begin
        phase  <= PH_PAYLOAD;
        dir_wr <= hdr.wr;
        ptr    <= hdr.loc;
      end else begin
        ptr <= ptr_next;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sdo_oe <= 1'b0;
    else     sdo_oe <= ce_s && (phase == PH_PAYLOAD) && (spi_mode || !dir_wr);
  end

  // R8
  oe_closed_chk: assert property (@(posedge clk) disable iff (rst)
    !ce_s |=> !sdo_oe);

  // R8
  oe_header_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HEADER) |=> !sdo_oe);

  // R4
  clk_window_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (stepping && ptr < CLK_LIM) |=> ptr < CLK_LIM);

  // R5
  ram_window_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (stepping && ptr >= CLK_LIM) |=> ptr >= CLK_LIM);

endmodule

// File: tb/dual_serial_regport_bench.sv
module dual_serial_regport_bench;

  localparam int H = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_mode = 1'b1;
  logic ce = 1'b0;
  logic sclk = 1'b0;
  logic host_d = 1'b0;
  logic tick = 1'b0;
  logic sdo, sdo_oe, sdi;

  int   n_chk = 0;
  int   n_bad = 0;
  int   tick_off = -1;
  logic cur_idle = 1'b0;
  logic [7:0] exp_live [16];
  logic [7:0] exp_ram  [96];

  assign sdi = (!spi_mode && sdo_oe) ? sdo : host_d;

  always #4 clk = ~clk;

  dual_serial_regport u_dual_serial_regport (
    .clk(clk), .rst(rst), .spi_mode(spi_mode), .ce(ce), .sclk(sclk),
    .sdi(sdi), .tick(tick), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [6:0] next_loc(input logic [6:0] l);
    if (l < 7'd32) return (l == 7'd31) ? 7'd0 : l + 7'd1;
    return (l == 7'd127) ? 7'd32 : l + 7'd1;
  endfunction

  function automatic logic [7:0] exp_of(input logic [6:0] l);
    if (l < 7'd16) return exp_live[l[3:0]];
    if (l < 7'd32) return 8'h00;
    return exp_ram[l - 7'd32];
  endfunction

  task automatic xbits(input logic [7:0] tx, input int nb, input bit oe_off,
                       input string tag, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nb; i++) begin
      host_d = spi_mode ? tx[7-i] : tx[i];
      idle(H);
      if (spi_mode) rx[7-i] = sdo; else rx[i] = sdo;
      if (oe_off) chk(sdo_oe == 1'b0, tag, sdo_oe, 0);
      sclk = ~cur_idle;
      if (i == 7 && tick_off >= 0) begin
        repeat (3 + tick_off) @(posedge clk);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
      end
      idle(H);
      sclk = cur_idle;
    end
  endtask

  task automatic open_frame(input logic idle_lvl);
    cur_idle = idle_lvl;
    sclk = idle_lvl;
    idle(H);
    ce = 1'b1;
    idle(H);
  endtask

  task automatic close_frame();
    idle(H);
    ce = 1'b0;
    idle(3 * H);
  endtask

  task automatic wr_burst(input logic [6:0] start, input int n, input int seed,
                          input logic idle_lvl);
    logic [7:0] rx;
    logic [6:0] l;
    logic [7:0] v;
    open_frame(idle_lvl);
    xbits({1'b1, start}, 8, 1'b1, "R8 header oe", rx);
    l = start;
    for (int k = 0; k < n; k++) begin
      v = 8'((int'(l) * 11 + seed * 41 + 3) ^ 8'hC3);
      xbits(v, 8, !spi_mode, "R8 three-wire write oe", rx);
      if (l < 7'd16) exp_live[l[3:0]] = v;
      else if (l >= 7'd32) exp_ram[l - 7'd32] = v;
      l = next_loc(l);
    end
    close_frame();
  endtask

  task automatic rd_burst(input logic [6:0] start, input int n, input logic idle_lvl,
                          input string tag);
    logic [7:0] rx;
    logic [6:0] l;
    open_frame(idle_lvl);
    xbits({1'b0, start}, 8, 1'b1, "R8 header oe", rx);
    l = start;
    for (int k = 0; k < n; k++) begin
      xbits(8'h00, 8, 1'b0, tag, rx);
      chk(rx == exp_of(l), tag, rx, exp_of(l));
      l = next_loc(l);
    end
    close_frame();
  endtask

  task automatic wr_one(input logic [6:0] loc, input logic [7:0] v,
                        input logic idle_lvl);
    logic [7:0] rx;
    open_frame(idle_lvl);
    xbits({1'b1, loc}, 8, 1'b1, "R8 header oe", rx);
    xbits(v, 8, !spi_mode, "R8 three-wire write oe", rx);
    close_frame();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    logic [7:0] first;
    logic [7:0] d;
    for (int i = 0; i < 16; i++) exp_live[i] = 8'h00;
    for (int i = 0; i < 96; i++) exp_ram[i] = 8'h00;
    idle(5);
    rst = 1'b0;
    idle(3);
    chk(sdo_oe == 1'b0, "R12 reset oe", sdo_oe, 0);
    rd_burst(7'h00, 32, 1'b0, "R12 reset clock window");

    for (int m = 1; m >= 0; m--) begin
      for (int c = 0; c < 2; c++) begin
        int seed;
        seed = m * 2 + c;
        spi_mode = m[0];
        idle(4);
        // R5 R3 R1 R7: RAM burst crossing 0x7F -> 0x20
        wr_burst(7'h7E, 4, seed, c[0]);
        rd_burst(7'h7E, 4, c[0], "R5 R1 R7 RAM wrap read");
        // R4 R9 R2: clock write crossing 0x1F -> 0x00, then full wrap read
        wr_burst(7'h1E, 20, seed, c[0]);
        rd_burst(7'h00, 33, c[0], "R4 R9 R2 clock wrap read");

        // R6: ticks inside a read burst leave the frozen copy alone
        open_frame(c[0]);
        xbits(8'h00, 8, 1'b1, "R8 header oe", rx);
        xbits(8'h00, 8, 1'b0, "R6 first", first);
        chk(first == exp_live[0], "R6 first read", first, exp_live[0]);
        for (int t = 0; t < 5; t++) begin
          tick = 1'b1;
          idle(1);
          tick = 1'b0;
          idle(1);
        end
        exp_live[0] = exp_live[0] + 8'd5;
        for (int k = 1; k <= 32; k++) begin
          logic [6:0] l;
          logic [7:0] e;
          l = 7'(k % 32);
          e = (l == 7'd0) ? first : exp_of(l);
          xbits(8'h00, 8, 1'b0, "R6 burst", rx);
          chk(rx == e, "R6 frozen burst", rx, e);
        end
        close_frame();
        rd_burst(7'h00, 1, c[0], "R6 advanced after new read");

        // R10: frame closed after four data bits
        d = 8'(seed * 17 + 9);
        wr_one(7'h03, d, c[0]);
        exp_live[3] = d;
        open_frame(c[0]);
        xbits(8'h83, 8, 1'b1, "R8 header oe", rx);
        xbits(~d, 4, 1'b0, "R10 partial", rx);
        close_frame();
        rd_burst(7'h03, 1, c[0], "R10 aborted byte");

        // R11: tick exactly on the commit cycle, then one cycle late
        d = 8'(seed * 23 + 40);
        tick_off = 0;
        wr_one(7'h00, d, c[0]);
        tick_off = -1;
        exp_live[0] = d;
        rd_burst(7'h00, 1, c[0], "R11 write wins over tick");
        tick_off = 1;
        wr_one(7'h00, d + 8'd2, c[0]);
        tick_off = -1;
        exp_live[0] = d + 8'd3;
        rd_burst(7'h00, 1, c[0], "R11 tick after write");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule